// File: doc/BRIEF.md
# Banked ROM/RAM Cartridge Mapper

This block sits on the write side of a 16-bit address bus and turns CPU stores into the lower 32 KiB into bank selections for a cartridge memory system. Four write regions, picked by address bits [15:13], hold a RAM gate flag, a low bank field, a two-bit high field and a mapping mode. From these the block produces the physical ROM bank for the switchable upper 16 KiB window, the bank for the lower 16 KiB window, the external RAM bank and the RAM enable. The ROM and RAM arrays, read data steering and header parsing all live elsewhere.

A static configuration pin selects a 4-bit stride for multicart images instead of the normal 5-bit stride. The stride sets where the high field lands in the bank number. The ROM size is a power-of-two parameter counted in 16 KiB banks. Bank numbers that run past the ROM wrap modulo that size. A wrapped upper-window bank of zero becomes one.

The mapping mode is a two-state machine. In state MODE_ROM_ONLY the lower window is pinned to bank 0 and the RAM bank to 0. In state MODE_SPLIT the high field also drives the lower window and the RAM bank. The transition MODE_ROM_ONLY to MODE_SPLIT happens on a mode write with data bit 0 set. The transition MODE_SPLIT to MODE_ROM_ONLY happens on a mode write with data bit 0 clear. Reset enters MODE_ROM_ONLY.

Top module: `cart_bank_mapper`

## Requirements
- R1: A write is taken only when wr_en is high and wr_addr[15] is 0. wr_addr[14:13] picks the region: 0 RAM gate, 1 low field, 2 high field, 3 mode. Writes with wr_addr[15]=1, and cycles with wr_en low, change no output.
- R2: A RAM-gate write with data 0x0A sets ram_en_o. Data 0x00 clears it. Any other value leaves it unchanged.
- R3: A low-field write takes data[4:0] and ignores data[7:5]. A value of 0 is replaced by 1, and the result is then masked to the stride width. With the 4-bit stride, data 0x10 therefore leaves a low field of 0.
- R4: The upper-window bank before wrapping is (high << S) | low, where S is 5 when stride4_cfg=0 and 4 when stride4_cfg=1. A mode write does not change it.
- R5: A high-field write stores data[1:0]. In MODE_SPLIT the same value also sets the lower window to (value << S) and the RAM bank to the value.
- R6: A mode write with data[0]=0 enters MODE_ROM_ONLY and forces the lower window and RAM bank to 0. With data[0]=1 it enters MODE_SPLIT, sets the lower window from the current high field and leaves the RAM bank alone. In MODE_ROM_ONLY, high-field writes leave the lower window and RAM bank at 0.
- R7: Both window banks are reduced modulo ROM_BANKS. An upper-window result of 0 after reduction is output as 1.
- R8: Reset gives upper bank 1, lower bank 0, RAM bank 0, RAM disabled and MODE_ROM_ONLY. Outputs are registered and show a write's effect from the clock edge that takes the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stride4_cfg | input | 1 | Static: 1 selects the 4-bit multicart stride, 0 the 5-bit stride |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 16 | Write address |
| wr_data | input | 8 | Write data |
| hi_bank_o | output | $clog2(ROM_BANKS) | ROM bank for the upper 16 KiB window |
| lo_bank_o | output | $clog2(ROM_BANKS) | ROM bank for the lower 16 KiB window |
| ram_bank_o | output | 2 | External RAM bank |
| ram_en_o | output | 1 | External RAM enable |

## Verification
The assertions take for granted that stride4_cfg only changes while rst_n is low and that ROM_BANKS is a power of two of at least 2. The low-field non-zero check and the pinned-to-zero check in MODE_ROM_ONLY depend on those two facts. The bench changes the stride only inside a reset pulse and uses a 64-bank ROM. This is small enough that the high field wraps, which exercises the zero-to-one substitution after reduction. Its directed writes and a long stretch of pseudo-random writes all stay within those limits.

// File: rtl/cbm_pkg.sv
`timescale 1ns/1ps
package cbm_pkg;

    // Write region selected by address bits [14:13] (bit 15 must be 0)
    typedef enum logic [1:0] {
        RGN_RAM_GATE  = 2'd0,
        RGN_LOW_SEL   = 2'd1,
        RGN_HIGH_SEL  = 2'd2,
        RGN_MODE      = 2'd3
    } region_e;

    // Mapping mode state machine
    typedef enum logic {
        MODE_ROM_ONLY = 1'b0,
        MODE_SPLIT    = 1'b1
    } map_mode_e;

    // One strobe per write region
    typedef struct packed {
        logic gate;
        logic low;
        logic high;
        logic mode;
    } wr_strobe_t;

    localparam logic [7:0] GATE_ON  = 8'h0A;
    localparam logic [7:0] GATE_OFF = 8'h00;

    localparam int LOW_W  = 5;
    localparam int HIGH_W = 2;
    localparam int RAW_W  = LOW_W + HIGH_W;

endpackage

// File: rtl/cbm_decode.sv
`timescale 1ns/1ps
module cbm_decode
    import cbm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [15:0] wr_addr,
    output wr_strobe_t  strobe
);

    region_e rgn;
    logic    in_range;
    logic    offset_unused;

    assign offset_unused = ^wr_addr[12:0];

    always_comb begin
        rgn      = region_e'(wr_addr[14:13]);
        in_range = wr_en && !wr_addr[15];
        strobe   = '0;
        if (in_range) begin
            unique case (rgn)
                RGN_RAM_GATE: strobe.gate = 1'b1;
                RGN_LOW_SEL:  strobe.low  = 1'b1;
                RGN_HIGH_SEL: strobe.high = 1'b1;
                RGN_MODE:     strobe.mode = 1'b1;
                default:      strobe      = '0;
            endcase
        end
    end

    AST_ONE_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strobe)); // R1

    AST_UPPER_HALF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_addr[15] || !wr_en) |-> (strobe == '0)); // R1

endmodule

// File: rtl/cbm_fields.sv
`timescale 1ns/1ps
module cbm_fields
    import cbm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stride4,
    input  wr_strobe_t        strobe,
    input  logic [7:0]        wr_data,
    output logic [LOW_W-1:0]  low_d,
    output logic [HIGH_W-1:0] high_d,
    output logic [HIGH_W-1:0] lo_sel_d,
    output logic [HIGH_W-1:0] ram_bank_q,
    output logic              ram_en_q,
    output map_mode_e         mode_q
);

    map_mode_e         mode_d;
    logic [LOW_W-1:0]  low_q;
    logic [HIGH_W-1:0] high_q;
    logic [HIGH_W-1:0] lo_sel_q;
    logic [HIGH_W-1:0] ram_bank_d;
    logic              ram_en_d;
    logic [LOW_W-1:0]  low_sub;
    logic [LOW_W-1:0]  low_masked;

    // Zero-to-one substitution happens before the stride mask
    always_comb begin
        low_sub    = (wr_data[LOW_W-1:0] == '0) ? LOW_W'(1) : wr_data[LOW_W-1:0];
        low_masked = stride4 ? {1'b0, low_sub[LOW_W-2:0]} : low_sub;
    end

    // State register for the mapping mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_ROM_ONLY;
        else        mode_q <= mode_d;
    end

    // Next-state logic
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_ROM_ONLY: if (strobe.mode && wr_data[0])  mode_d = MODE_SPLIT;
            MODE_SPLIT:    if (strobe.mode && !wr_data[0]) mode_d = MODE_ROM_ONLY;
            default:       mode_d = MODE_ROM_ONLY;
        endcase
    end

    // Field updates driven by the region strobes and the current mode
    always_comb begin
        low_d      = low_q;
        high_d     = high_q;
        lo_sel_d   = lo_sel_q;
        ram_bank_d = ram_bank_q;
        ram_en_d   = ram_en_q;
        if (strobe.gate) begin
            if (wr_data == GATE_ON)       ram_en_d = 1'b1;
            else if (wr_data == GATE_OFF) ram_en_d = 1'b0;
        end
        if (strobe.low) low_d = low_masked;
        if (strobe.high) begin
            high_d = wr_data[HIGH_W-1:0];
            if (mode_q == MODE_SPLIT) begin
                lo_sel_d   = wr_data[HIGH_W-1:0];
                ram_bank_d = wr_data[HIGH_W-1:0];
            end
        end
        if (strobe.mode) begin
            if (wr_data[0]) begin
                lo_sel_d = high_q;
            end else begin
                lo_sel_d   = '0;
                ram_bank_d = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_q      <= LOW_W'(1);
            high_q     <= '0;
            lo_sel_q   <= '0;
            ram_bank_q <= '0;
            ram_en_q   <= 1'b0;
        end else begin
            low_q      <= low_d;
            high_q     <= high_d;
            lo_sel_q   <= lo_sel_d;
            ram_bank_q <= ram_bank_d;
            ram_en_q   <= ram_en_d;
        end
    end

    AST_LOW_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !stride4 |-> (low_q != '0)); // R3

    AST_RAMEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe.gate && wr_data != GATE_ON && wr_data != GATE_OFF) |=> $stable(ram_en_q)); // R2

    AST_GATE_ON_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe.gate && wr_data == GATE_ON) |=> ram_en_q); // R2

endmodule

// File: rtl/cbm_wrap.sv
`timescale 1ns/1ps
module cbm_wrap
    import cbm_pkg::*;
#(
    parameter int ROM_BANKS     = 64,
    parameter int BANK_W        = 6,
    parameter bit FORCE_NONZERO = 1'b0
) (
    input  logic              stride4,
    input  logic [HIGH_W-1:0] high,
    input  logic [LOW_W-1:0]  low,
    output logic [BANK_W-1:0] bank
);

    localparam logic [BANK_W-1:0] MASK = BANK_W'(ROM_BANKS - 1);

    logic [RAW_W-1:0]  raw;
    logic [BANK_W-1:0] masked;

    // Place the high field above a 4- or 5-bit low field
    assign raw = stride4 ? {1'b0, high, low[LOW_W-2:0]} : {high, low};

    generate
        if (BANK_W >= RAW_W) begin : g_wide
            assign masked = BANK_W'(raw) & MASK;
        end else begin : g_narrow
            logic drop_unused;
            assign drop_unused = ^raw[RAW_W-1:BANK_W];
            assign masked = raw[BANK_W-1:0] & MASK;
        end

        if (FORCE_NONZERO) begin : g_nonzero
            assign bank = (masked == '0) ? BANK_W'(1) : masked;
        end else begin : g_plain
            assign bank = masked;
        end
    endgenerate

endmodule

// File: rtl/cart_bank_mapper.sv
`timescale 1ns/1ps
module cart_bank_mapper
    import cbm_pkg::*;
#(
    parameter int ROM_BANKS = 64,
    localparam int BANK_W   = (ROM_BANKS > 2) ? $clog2(ROM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stride4_cfg,
    input  logic              wr_en,
    input  logic [15:0]       wr_addr,
    input  logic [7:0]        wr_data,
    output logic [BANK_W-1:0] hi_bank_o,
    output logic [BANK_W-1:0] lo_bank_o,
    output logic [1:0]        ram_bank_o,
    output logic              ram_en_o
);

    wr_strobe_t        strobe;
    logic [LOW_W-1:0]  low_d;
    logic [HIGH_W-1:0] high_d;
    logic [HIGH_W-1:0] lo_sel_d;
    map_mode_e         mode_q;
    logic [BANK_W-1:0] hi_next;
    logic [BANK_W-1:0] lo_next;

    cbm_decode u_decode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .strobe  (strobe)
    );

    cbm_fields u_fields (
        .clk        (clk),
        .rst_n      (rst_n),
        .stride4    (stride4_cfg),
        .strobe     (strobe),
        .wr_data    (wr_data),
        .low_d      (low_d),
        .high_d     (high_d),
        .lo_sel_d   (lo_sel_d),
        .ram_bank_q (ram_bank_o),
        .ram_en_q   (ram_en_o),
        .mode_q     (mode_q)
    );

    cbm_wrap #(.ROM_BANKS(ROM_BANKS), .BANK_W(BANK_W), .FORCE_NONZERO(1'b1)) u_wrap_hi (
        .stride4 (stride4_cfg),
        .high    (high_d),
        .low     (low_d),
        .bank    (hi_next)
    );

    cbm_wrap #(.ROM_BANKS(ROM_BANKS), .BANK_W(BANK_W), .FORCE_NONZERO(1'b0)) u_wrap_lo (
        .stride4 (stride4_cfg),
        .high    (lo_sel_d),
        .low     ('0),
        .bank    (lo_next)
    );

    // Registered bank outputs, loaded from the next field values
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_bank_o <= BANK_W'(1);
            lo_bank_o <= '0;
        end else begin
            hi_bank_o <= hi_next;
            lo_bank_o <= lo_next;
        end
    end

    AST_HI_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        hi_bank_o != '0); // R7

    AST_ROM_ONLY_PINNED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_ROM_ONLY) |-> (lo_bank_o == '0 && ram_bank_o == '0)); // R6

    AST_MODE_WR_HI_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        strobe.mode |=> $stable(hi_bank_o)); // R4

    AST_HIGH_HALF_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[15]) |=> ($stable(hi_bank_o) && $stable(lo_bank_o)
                                    && $stable(ram_bank_o) && $stable(ram_en_o))); // R1

endmodule

// File: tb/sim_cart_bank_mapper.sv
`timescale 1ns/1ps
module sim_cart_bank_mapper;

    localparam int NB = 64;
    localparam int BW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stride4 = 1'b0;
    logic          wr_en = 1'b0;
    logic [15:0]   wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [BW-1:0] hi_bank, lo_bank;
    logic [1:0]    ram_bank;
    logic          ram_en;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;
    bit run_cmp = 0;

    always #2.5 clk = ~clk;

    cart_bank_mapper #(.ROM_BANKS(NB)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .stride4_cfg (stride4),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .hi_bank_o   (hi_bank),
        .lo_bank_o   (lo_bank),
        .ram_bank_o  (ram_bank),
        .ram_en_o    (ram_en)
    );

    // Behavioural reference state
    int m_low = 1, m_up = 0, m_mode = 0, m_losel = 0, m_ram = 0, m_en = 0;

    function automatic int stride_bits();
        return stride4 ? 4 : 5;
    endfunction

    function automatic int exp_hi();
        int v;
        v = ((m_up << stride_bits()) | m_low) % NB;
        if (v == 0) v = 1;
        return v;
    endfunction

    function automatic int exp_lo();
        return (m_losel << stride_bits()) % NB;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_low = 1; m_up = 0; m_mode = 0; m_losel = 0; m_ram = 0; m_en = 0;
        end else if (wr_en && !wr_addr[15]) begin
            case (int'(wr_addr[14:13]))
                0: begin
                    if (wr_data == 8'h0A) m_en = 1;
                    else if (wr_data == 8'h00) m_en = 0;
                end
                1: begin
                    int b;
                    b = wr_data & 31;
                    if (b == 0) b = 1;
                    m_low = b % (1 << stride_bits());
                end
                2: begin
                    m_up = wr_data & 3;
                    if (m_mode == 1) begin m_losel = m_up; m_ram = m_up; end
                end
                default: begin
                    m_mode = wr_data & 1;
                    if (m_mode == 1) m_losel = m_up;
                    else begin m_losel = 0; m_ram = 0; end
                end
            endcase
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // Compare against the model on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && run_cmp && !done) begin
            check("R4/R7 upper-window bank", int'(hi_bank), exp_hi());
            check("R5/R6 lower-window bank", int'(lo_bank), exp_lo());
            check("R5/R6 RAM bank", int'(ram_bank), m_ram);
            check("R2 RAM enable", int'(ram_en), m_en);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            bad++;
            total++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 100000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset(input logic mc);
        @(negedge clk);
        rst_n = 1'b0;
        stride4 = mc;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 reset upper bank", int'(hi_bank), 1);
        check("R8 reset lower bank", int'(lo_bank), 0);
        check("R8 reset RAM bank", int'(ram_bank), 0);
        check("R8 reset RAM enable", int'(ram_en), 0);
    endtask

    initial begin
        logic [15:0] lf;
        do_reset(1'b0);
        run_cmp = 1;

        // RAM gate
        wr(16'h0000, 8'h0A); check("R2 enable on 0x0A", int'(ram_en), 1);
        wr(16'h1FFF, 8'h05); check("R2 other value holds", int'(ram_en), 1);
        wr(16'h0123, 8'h00); check("R2 disable on 0x00", int'(ram_en), 0);
        wr(16'h0000, 8'h0A);

        // Low field, 5-bit stride
        wr(16'h2000, 8'h00); check("R3 zero becomes one", int'(hi_bank), 1);
        wr(16'h3FFF, 8'h1F); check("R3 low field 31", int'(hi_bank), 31);
        wr(16'h2100, 8'hE5); check("R3 bits 7:5 ignored", int'(hi_bank), 5);

        // High field in ROM-only mode
        wr(16'h4000, 8'h01); check("R4 high field shift by 5", int'(hi_bank), 37);
        check("R6 lower pinned in ROM-only", int'(lo_bank), 0);
        wr(16'h4000, 8'h02); check("R7 wrap modulo 64", int'(hi_bank), 5);
        check("R6 RAM bank pinned in ROM-only", int'(ram_bank), 0);
        wr(16'h2000, 8'h01); wr(16'h4000, 8'h01);

        // Split mode
        wr(16'h6000, 8'hFF); check("R6 mode 1 copies high to lower", int'(lo_bank), 32);
        check("R6 mode 1 leaves RAM bank", int'(ram_bank), 0);
        check("R4 mode write keeps upper", int'(hi_bank), 33);
        wr(16'h4000, 8'h03); check("R5 split lower window", int'(lo_bank), 32);
        check("R5 split RAM bank", int'(ram_bank), 3);
        check("R5 split upper wraps", int'(hi_bank), 33);

        // Ignored writes
        wr(16'h8000, 8'h00); check("R1 upper half ignored", int'(ram_en), 1);
        wr(16'hE000, 8'h00); check("R1 upper half mode alias ignored", int'(ram_bank), 3);
        @(negedge clk); wr_addr = 16'h0000; wr_data = 8'h00;
        @(negedge clk); check("R1 no strobe no change", int'(ram_en), 1);

        // Back to ROM-only
        wr(16'h7FFF, 8'h00); check("R6 mode 0 clears lower", int'(lo_bank), 0);
        check("R6 mode 0 clears RAM bank", int'(ram_bank), 0);
        wr(16'h4000, 8'h02); check("R6 high write in ROM-only keeps RAM bank", int'(ram_bank), 0);
        check("R7 upper 65 wraps to 1", int'(hi_bank), 1);

        // 4-bit stride
        do_reset(1'b1);
        wr(16'h2000, 8'h10); check("R7 wrapped zero becomes one", int'(hi_bank), 1);
        wr(16'h4000, 8'h01); check("R3 0x10 masks to low 0", int'(hi_bank), 16);
        wr(16'h2000, 8'h00); check("R3 zero becomes one before mask", int'(hi_bank), 17);
        wr(16'h2000, 8'h1F); check("R4 stride 4 layout", int'(hi_bank), 31);
        wr(16'h4000, 8'h03); check("R4 stride 4 high 3", int'(hi_bank), 63);
        wr(16'h6000, 8'h01); check("R6 stride 4 lower window", int'(lo_bank), 48);
        wr(16'h4000, 8'h02); check("R5 stride 4 lower window", int'(lo_bank), 32);
        check("R5 stride 4 RAM bank", int'(ram_bank), 2);
        check("R8 write visible after edge", int'(hi_bank), 47);

        // Pseudo-random traffic, compared by the model every clock
        lf = 16'hACE1;
        for (int k = 0; k < 2; k++) begin
            do_reset(logic'(k));
            for (int i = 0; i < 400; i++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                if (lf[3:0] == 4'h0) begin
                    @(negedge clk);
                    wr_addr = lf; wr_data = lf[7:0];
                end else begin
                    wr(lf, lf[7:0] ^ lf[15:8]);
                end
            end
        end

        repeat (2) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule